// File: doc/BRIEF.md
# DRAM Command Event Counter Bank

This block sits next to one DRAM controller channel and counts the commands that the controller issues. Every cycle the controller presents its command activity on a handful of strobes: an activate, a vector of CAS sub-types (two read kinds and two write kinds), a precharge with a flag marking whether a row conflict caused it, and a precharge-all. Four counters, each 48 bits wide, can each be aimed at one command class. A counter's configuration holds an event code that picks the command type and a unit-mask byte that picks which sub-types of that type count. Software can tell row-conflict precharges apart from timer closes and from precharge-all, which refresh and power-state changes issue.

Software programs, reads, preloads, enables and freezes the counters through a plain register port. The port has a write strobe, an address, and a read-data output that follows the address in the same cycle. Each CAS stands for one 64-byte transfer, so software gets traffic in bytes by scaling a read or write CAS count by 64. Ratios such as hit, empty and conflict fractions are left to software.

Top module: `dram_cmd_perfmon`

## Requirements
- R1: After reset, every counter, every configuration register, the control register and all overflow flags read as zero.
- R2: Event code 0x01 adds one for every cycle in which `act_i` is high, whatever the unit mask holds.
- R3: Event code 0x04 adds the number of set bits in `cas_kind_i & umask[3:0]` each cycle. Bits 0 and 1 are the read kinds and bits 2 and 3 the write kinds. Mask 0x03 counts all reads, mask 0x0C counts all writes, and mask 0x0F adds a read and a write arriving in one cycle as two.
- R4: Event code 0x02 counts precharges by cause. Unit-mask bit 0 selects `pre_i` with `pre_conflict_i` high (a row conflict), and bit 1 selects `pre_i` with `pre_conflict_i` low. `prea_i` never counts under this code.
- R5: Event code 0x03 adds one for every cycle with `prea_i` high, whatever the unit mask holds. Any code other than 0x01 to 0x04 counts nothing.
- R6: A counter advances only while control bit 0 (global enable) is set, its configuration bit 16 (counter enable) is set, and control bit 1 (freeze) is clear. Setting freeze holds all four counters.
- R7: An event seen at a clock edge shows in the counter's read value from that edge on. Before that edge the read value is the old count.
- R8: A counter wraps modulo 2^48. On a wrap it sets its sticky overflow flag, which is bit i of the status register at address 1 and of `ovf_o`. Writing 1 to that status bit clears the flag, and writing 0 leaves it unchanged. If a wrap and a clear fall in the same cycle, the wrap wins.
- R9: A write to a counter address loads the written low 48 bits. The load takes priority over any increment in that cycle, and that cycle raises no overflow.
- R10: The register map is as follows. Address 0 is control, address 1 is overflow status, and addresses 4 to 7 hold configuration 0 to 3, with the code in bits 7:0, the unit mask in bits 15:8 and the enable in bit 16. Addresses 8 to 11 hold counters 0 to 3. Unused addresses read zero, and configuration reads back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_i | input | 1 | Activate issued this cycle |
| cas_kind_i | input | 4 | CAS sub-types issued this cycle (bits 1:0 read kinds, 3:2 write kinds) |
| pre_i | input | 1 | Single-bank precharge issued this cycle |
| pre_conflict_i | input | 1 | Precharge cause: row conflict (1) or other close (0) |
| prea_i | input | 1 | Precharge-all issued this cycle |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Read data for `reg_addr_i`, same cycle |
| ovf_o | output | 4 | Sticky overflow flags, one per counter |

## Verification
There is one register stage between a command strobe and a visible count, and between a register write and its effect. Read data follows the address with no register. The bench drives each stimulus just after a rising edge. It queues an expected read for a later cycle and compares it at the falling edge of that cycle, so a count is checked one edge after its event. One check looks at the event cycle itself to confirm that the old value still shows there. Wrap, load priority and clear priority are each driven within a single cycle, so the outcome depends only on that one edge.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

    localparam int INC_W = 3;

    localparam logic [7:0] EV_ACTIVATE = 8'h01;
    localparam logic [7:0] EV_PRECHG   = 8'h02;
    localparam logic [7:0] EV_PRECHG_A = 8'h03;
    localparam logic [7:0] EV_CAS      = 8'h04;

    typedef struct packed {
        logic       act;
        logic [3:0] cas;
        logic       pre;
        logic       pre_conflict;
        logic       prea;
    } cmd_evt_t;

    typedef struct packed {
        logic       en;
        logic [7:0] umask;
        logic [7:0] code;
    } ctr_cfg_t;

    localparam int CFG_W = $bits(ctr_cfg_t);

    // Number of matching command sub-types this cycle for one configuration.
    function automatic logic [INC_W-1:0] match_inc(ctr_cfg_t c, cmd_evt_t e);
        logic [3:0]       sub;
        logic [INC_W-1:0] res;
        sub = '0;
        res = '0;
        case (c.code)
            EV_ACTIVATE: res = {{(INC_W-1){1'b0}}, e.act};
            EV_PRECHG_A: res = {{(INC_W-1){1'b0}}, e.prea};
            EV_PRECHG: begin
                sub = {2'b00, e.pre & ~e.pre_conflict, e.pre & e.pre_conflict};
                res = INC_W'($countones(sub & c.umask[3:0]));
            end
            EV_CAS: begin
                sub = e.cas;
                res = INC_W'($countones(sub & c.umask[3:0]));
            end
            default: res = '0;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/perfmon_evt_match.sv
module perfmon_evt_match
    import perfmon_pkg::*;
(
    input  ctr_cfg_t         cfg_i,
    input  cmd_evt_t         evt_i,
    output logic [INC_W-1:0] inc_o
);
    always_comb begin
        inc_o = match_inc(cfg_i, evt_i);
    end
endmodule

// File: rtl/perfmon_counter.sv
module perfmon_counter
    import perfmon_pkg::*;
#(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             count_en_i,
    input  logic [INC_W-1:0] inc_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             clr_ovf_i,
    output logic [CNT_W-1:0] value_o,
    output logic             ovf_o
);
    logic [CNT_W:0] sum;

    always_comb begin
        sum = {1'b0, value_o} + (CNT_W+1)'(inc_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            value_o <= '0;
        end else if (load_i) begin
            value_o <= load_val_i;
        end else if (count_en_i) begin
            value_o <= sum[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_o <= 1'b0;
        end else if (!load_i && count_en_i && sum[CNT_W]) begin
            ovf_o <= 1'b1;
        end else if (clr_ovf_i) begin
            ovf_o <= 1'b0;
        end
    end
endmodule

// File: rtl/dram_cmd_perfmon.sv
module dram_cmd_perfmon
    import perfmon_pkg::*;
#(
    parameter int NUM_CTRS = 4,
    parameter int CNT_W    = 48,
    parameter int DATA_W   = 64,
    parameter int ADDR_W   = $clog2(3*NUM_CTRS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                act_i,
    input  logic [3:0]          cas_kind_i,
    input  logic                pre_i,
    input  logic                pre_conflict_i,
    input  logic                prea_i,
    input  logic                reg_wr_i,
    input  logic [ADDR_W-1:0]   reg_addr_i,
    input  logic [DATA_W-1:0]   reg_wdata_i,
    output logic [DATA_W-1:0]   reg_rdata_o,
    output logic [NUM_CTRS-1:0] ovf_o
);
    localparam int CTRL_ADDR = 0;
    localparam int STAT_ADDR = 1;
    localparam int CFG_BASE  = NUM_CTRS;
    localparam int CNT_BASE  = 2*NUM_CTRS;

    cmd_evt_t evt;
    logic     glob_en_q;
    logic     freeze_q;
    logic     run;
    logic     stat_wr;

    ctr_cfg_t [NUM_CTRS-1:0]             cfg_q;
    logic     [NUM_CTRS-1:0][CNT_W-1:0]  cnt_val;
    logic     [NUM_CTRS-1:0][INC_W-1:0]  inc;

    always_comb begin
        evt.act          = act_i;
        evt.cas          = cas_kind_i;
        evt.pre          = pre_i;
        evt.pre_conflict = pre_conflict_i;
        evt.prea         = prea_i;
        run              = glob_en_q & ~freeze_q;
        stat_wr          = reg_wr_i && (reg_addr_i == ADDR_W'(STAT_ADDR));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            glob_en_q <= 1'b0;
            freeze_q  <= 1'b0;
        end else if (reg_wr_i && (reg_addr_i == ADDR_W'(CTRL_ADDR))) begin
            glob_en_q <= reg_wdata_i[0];
            freeze_q  <= reg_wdata_i[1];
        end
    end

    for (genvar i = 0; i < NUM_CTRS; i++) begin : g_ctr
        localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_BASE + i);
        localparam logic [ADDR_W-1:0] CNT_A = ADDR_W'(CNT_BASE + i);

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[i] <= '0;
            end else if (reg_wr_i && (reg_addr_i == CFG_A)) begin
                cfg_q[i] <= ctr_cfg_t'(reg_wdata_i[CFG_W-1:0]);
            end
        end

        perfmon_evt_match u_match (
            .cfg_i (cfg_q[i]),
            .evt_i (evt),
            .inc_o (inc[i])
        );

        perfmon_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk        (clk),
            .rst        (rst),
            .count_en_i (run & cfg_q[i].en),
            .inc_i      (inc[i]),
            .load_i     (reg_wr_i && (reg_addr_i == CNT_A)),
            .load_val_i (reg_wdata_i[CNT_W-1:0]),
            .clr_ovf_i  (stat_wr & reg_wdata_i[i]),
            .value_o    (cnt_val[i]),
            .ovf_o      (ovf_o[i])
        );
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == ADDR_W'(CTRL_ADDR)) begin
            reg_rdata_o[1:0] = {freeze_q, glob_en_q};
        end
        if (reg_addr_i == ADDR_W'(STAT_ADDR)) begin
            reg_rdata_o[NUM_CTRS-1:0] = ovf_o;
        end
        for (int i = 0; i < NUM_CTRS; i++) begin
            if (reg_addr_i == ADDR_W'(CFG_BASE + i)) begin
                reg_rdata_o[CFG_W-1:0] = cfg_q[i];
            end
            if (reg_addr_i == ADDR_W'(CNT_BASE + i)) begin
                reg_rdata_o[CNT_W-1:0] = cnt_val[i];
            end
        end
    end
endmodule

// File: rtl/perfmon_chk.sv
module perfmon_chk #(
    parameter int NUM_CTRS = 4,
    parameter int CNT_W    = 48,
    parameter int DATA_W   = 64,
    parameter int ADDR_W   = 4
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           reg_wr_i,
    input logic [ADDR_W-1:0]              reg_addr_i,
    input logic [DATA_W-1:0]              reg_wdata_i,
    input logic [NUM_CTRS-1:0]            ovf_o,
    input logic                           glob_en_q,
    input logic                           freeze_q,
    input logic [NUM_CTRS-1:0][CNT_W-1:0] cnt_val
);
    localparam int CNT_BASE = 2*NUM_CTRS;

    // R6
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (freeze_q && !reg_wr_i) |=> $stable(cnt_val));

    // R6
    global_off_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!glob_en_q && !reg_wr_i) |=> $stable(cnt_val));

    for (genvar i = 0; i < NUM_CTRS; i++) begin : g_chk
        // R9
        load_wins_chk: assert property (@(posedge clk) disable iff (rst)
            (reg_wr_i && reg_addr_i == ADDR_W'(CNT_BASE + i))
            |=> cnt_val[i] == $past(reg_wdata_i[CNT_W-1:0]));

        // R8
        ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            (ovf_o[i] && !(reg_wr_i && reg_addr_i == ADDR_W'(1) && reg_wdata_i[i]))
            |=> ovf_o[i]);

        // R8
        ovf_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(ovf_o[i]) |-> (cnt_val[i] < CNT_W'(4)));

        // R3
        step_bound_chk: assert property (@(posedge clk) disable iff (rst)
            !(reg_wr_i && reg_addr_i == ADDR_W'(CNT_BASE + i))
            |=> (CNT_W'(cnt_val[i] - $past(cnt_val[i])) <= CNT_W'(4)));
    end
endmodule

bind dram_cmd_perfmon perfmon_chk #(
    .NUM_CTRS (NUM_CTRS),
    .CNT_W    (CNT_W),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .ovf_o       (ovf_o),
    .glob_en_q   (glob_en_q),
    .freeze_q    (freeze_q),
    .cnt_val     (cnt_val)
);

// File: tb/dram_cmd_perfmon_test.sv
module dram_cmd_perfmon_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        act_i = 1'b0;
    logic [3:0]  cas_kind_i = '0;
    logic        pre_i = 1'b0;
    logic        pre_conflict_i = 1'b0;
    logic        prea_i = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic [3:0]  reg_addr_i = '0;
    logic [63:0] reg_wdata_i = '0;
    logic [63:0] reg_rdata_o;
    logic [3:0]  ovf_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [63:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sbq[$];

    dram_cmd_perfmon uut (
        .clk            (clk),
        .rst            (rst),
        .act_i          (act_i),
        .cas_kind_i     (cas_kind_i),
        .pre_i          (pre_i),
        .pre_conflict_i (pre_conflict_i),
        .prea_i         (prea_i),
        .reg_wr_i       (reg_wr_i),
        .reg_addr_i     (reg_addr_i),
        .reg_wdata_i    (reg_wdata_i),
        .reg_rdata_o    (reg_rdata_o),
        .ovf_o          (ovf_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: compare the expected item queued in this cycle at the falling edge.
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            sb_item_t it;
            it = sbq.pop_front();
            checks++;
            if (reg_rdata_o !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", it.tag, reg_rdata_o, it.exp);
            end
        end
    end

    // One cycle of stimulus; events and register write together.
    task automatic cyc(input logic a, input logic [3:0] c, input logic p,
                       input logic pc, input logic pa, input logic w,
                       input logic [3:0] ad, input logic [63:0] d);
        @(posedge clk);
        #1;
        act_i = a; cas_kind_i = c; pre_i = p; pre_conflict_i = pc; prea_i = pa;
        reg_wr_i = w; reg_addr_i = ad; reg_wdata_i = d;
    endtask

    task automatic ev(input logic a, input logic [3:0] c, input logic p,
                      input logic pc, input logic pa);
        cyc(a, c, p, pc, pa, 1'b0, 4'd0, 64'd0);
    endtask

    task automatic wr(input logic [3:0] ad, input logic [63:0] d);
        cyc(1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1, ad, d);
    endtask

    // Driver side of the scoreboard: idle cycle with a read, expectation queued.
    task automatic rd(input logic [3:0] ad, input logic [63:0] e, input string tag);
        sb_item_t it;
        cyc(1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, ad, 64'd0);
        it.exp = e; it.tag = tag;
        sbq.push_back(it);
    endtask

    function automatic logic [63:0] cfg(input logic en, input logic [7:0] m, input logic [7:0] code);
        return {47'd0, en, m, code};
    endfunction

    localparam logic [63:0] TOP = 64'h0000_FFFF_FFFF_FFFF;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 / R10 reset state
        rd(4'd0, 64'd0, "R1 ctrl after reset");
        rd(4'd1, 64'd0, "R1 status after reset");
        rd(4'd4, 64'd0, "R1 cfg0 after reset");
        rd(4'd8, 64'd0, "R1 cnt0 after reset");
        rd(4'd11, 64'd0, "R1 cnt3 after reset");

        wr(4'd0, 64'd1);
        wr(4'd4, cfg(1'b1, 8'h00, 8'h01));
        wr(4'd5, cfg(1'b1, 8'h03, 8'h04));
        wr(4'd6, cfg(1'b1, 8'h0C, 8'h04));
        wr(4'd7, cfg(1'b1, 8'h01, 8'h02));
        rd(4'd5, cfg(1'b1, 8'h03, 8'h04), "R10 cfg1 readback");
        rd(4'd0, 64'd1, "R10 ctrl readback");

        ev(1, 4'b0000, 0, 0, 0);
        ev(1, 4'b0000, 0, 0, 0);
        ev(1, 4'b0011, 0, 0, 0);
        ev(0, 4'b0011, 1, 1, 0);
        ev(0, 4'b0101, 1, 1, 0);
        ev(0, 4'b0000, 1, 0, 0);
        ev(0, 4'b0000, 0, 0, 1);
        ev(0, 4'b0000, 0, 0, 1);
        rd(4'd8, 64'd3, "R2 activate count");
        rd(4'd9, 64'd5, "R3 read CAS mask 0x03");
        rd(4'd10, 64'd1, "R3 write CAS mask 0x0C");
        rd(4'd11, 64'd2, "R4 conflict precharge excludes close and prea");

        // R7: old value during the event cycle, new one after the edge
        begin
            sb_item_t it;
            cyc(1, 4'b0000, 0, 0, 0, 1'b0, 4'd8, 64'd0);
            it.exp = 64'd3; it.tag = "R7 old value in event cycle";
            sbq.push_back(it);
        end
        rd(4'd8, 64'd4, "R7 new value next cycle");

        // Reconfigure
        wr(4'd4, cfg(1'b1, 8'hFF, 8'h07));
        wr(4'd5, cfg(1'b1, 8'h0F, 8'h04));
        wr(4'd6, cfg(1'b1, 8'h00, 8'h03));
        wr(4'd7, cfg(1'b1, 8'h02, 8'h02));
        for (int i = 8; i < 12; i++) wr(4'(i), 64'd0);
        ev(1, 4'b1111, 1, 0, 0);
        ev(0, 4'b0000, 1, 1, 1);
        rd(4'd8, 64'd0, "R5 unknown code counts nothing");
        rd(4'd9, 64'd4, "R3 mask 0x0F adds read and write together");
        rd(4'd10, 64'd1, "R5 precharge-all event");
        rd(4'd11, 64'd1, "R4 non-conflict close mask bit1");

        // R6 enables and freeze
        wr(4'd5, cfg(1'b0, 8'h0F, 8'h04));
        ev(0, 4'b1111, 0, 0, 0);
        rd(4'd9, 64'd4, "R6 counter enable off");
        wr(4'd5, cfg(1'b1, 8'h0F, 8'h04));
        wr(4'd0, 64'd3);
        ev(0, 4'b1111, 0, 0, 0);
        ev(1, 4'b1111, 0, 0, 1);
        rd(4'd9, 64'd4, "R6 freeze holds cnt1");
        rd(4'd10, 64'd1, "R6 freeze holds cnt2");
        wr(4'd0, 64'd0);
        ev(0, 4'b1111, 0, 0, 0);
        rd(4'd9, 64'd4, "R6 global enable off");
        wr(4'd0, 64'd1);
        ev(0, 4'b0001, 0, 0, 0);
        rd(4'd9, 64'd5, "R6 counting resumes");

        // R8 wrap and sticky flag
        wr(4'd9, TOP - 64'd1);
        ev(0, 4'b1111, 0, 0, 0);
        rd(4'd9, 64'd2, "R8 wrap modulo 2^48");
        rd(4'd1, 64'd2, "R8 overflow flag set");
        ev(0, 4'b0001, 0, 0, 0);
        wr(4'd1, 64'd0);
        rd(4'd1, 64'd2, "R8 flag sticky after write 0");
        wr(4'd1, 64'd2);
        rd(4'd1, 64'd0, "R8 flag cleared by write 1");

        // R8 wrap wins over clear in the same cycle
        wr(4'd9, TOP);
        cyc(0, 4'b0001, 0, 0, 0, 1'b1, 4'd1, 64'd2);
        rd(4'd1, 64'd2, "R8 wrap beats clear");
        rd(4'd9, 64'd0, "R8 wrap from all ones");
        wr(4'd1, 64'd2);

        // R9 load priority
        cyc(0, 4'b1111, 0, 0, 0, 1'b1, 4'd9, 64'd100);
        rd(4'd9, 64'd100, "R9 load beats increment");
        wr(4'd9, TOP);
        cyc(0, 4'b0001, 0, 0, 0, 1'b1, 4'd9, 64'd7);
        rd(4'd9, 64'd7, "R9 load value at wrap point");
        rd(4'd1, 64'd0, "R9 no overflow on load cycle");

        // R10 unused addresses
        rd(4'd2, 64'd0, "R10 unused addr 2");
        rd(4'd3, 64'd0, "R10 unused addr 3");
        rd(4'd12, 64'd0, "R10 unused addr 12");

        @(posedge clk);
        @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule